// File: doc/BRIEF.md
# Five-Step Integer Datapath

This block is the operand and result path of a small 32-bit load/store processor that spends five clock steps on each instruction. A sequencer outside the block supplies, cycle by cycle, the register-address fields of the current instruction, its raw immediate field and the control bits for each step. The block returns a memory address, store data and an equality flag for branch decisions.

Data moves through fixed holding registers that load on every clock edge. Two source registers are read together into the operand pair. The ALU result goes to the address/result holder and the store data to its own holder. A three-way selector then picks the value to retire: the ALU result, memory read data or a return address. On the last step that value is written into the register file when the sequencer allows it. There are no load enables on the holding registers, so the sequencer keeps each step's inputs valid for the cycle that uses them.

Top module: `dp_core`

## Requirements
- R1: After reset every register-file entry reads as zero, and `mem_addr` and `mem_wdata` are zero.
- R2: Both source registers named by `src_a_addr` and `src_b_addr` are read in the same cycle and captured at the next edge. Their ALU result appears on `mem_addr` one edge later, two edges after the addresses are applied.
- R3: With `use_imm` high the second ALU operand is the extended immediate. With `use_imm` low it is the captured second register.
- R4: The 16-bit `imm_field` is sign-extended to 32 bits when `imm_signed` is 1 and zero-extended when it is 0.
- R5: `alu_op` selects the ALU function: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 equality (result 1 when equal, else 0). Codes 5 to 7 give 0.
- R6: `cmp_eq` is 1 exactly when the captured first operand equals the selected second operand. It is valid one edge after the addresses are applied.
- R7: `mem_wdata` carries the captured second register value two edges after the addresses are applied.
- R8: `res_sel` picks the value retired at the third edge: 0 the ALU result, 1 `mem_rdata`, 2 `ret_addr`, 3 the ALU result.
- R9: With `rf_we` high during the fourth cycle, the retired value is written at the fourth edge into the register named by `dst_addr`. With `rf_we` low, no register changes.
- R10: Register 0 is an ordinary register that keeps whatever value is written to it.
- R11: A register read in the same cycle as it is written returns its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_addr | input | 5 | First source register index |
| src_b_addr | input | 5 | Second source register index |
| dst_addr | input | 5 | Destination register index |
| imm_field | input | 16 | Raw immediate |
| imm_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| use_imm | input | 1 | Second operand is immediate |
| alu_op | input | 3 | ALU function code |
| res_sel | input | 2 | Retired-value select |
| rf_we | input | 1 | Register write enable |
| mem_rdata | input | 32 | Memory read data |
| ret_addr | input | 32 | Return address for calls |
| mem_addr | output | 32 | ALU result holder / data address |
| mem_wdata | output | 32 | Store data holder |
| cmp_eq | output | 1 | Operand equality flag |

## Verification
Take the edge at which the source addresses are captured as edge one. `cmp_eq` is due after edge one, `mem_addr` and `mem_wdata` after edge two, the retired value after edge three, and the register write at edge four. The driver notes the cycle count when it applies an instruction and tags each expected item with its exact due cycle. The monitor compares each item only in the cycle it falls due, half a period after the edge. Write-back is confirmed by a later read-back instruction that passes the register through the ALU with an immediate of zero.

// File: rtl/dp_pkg.sv
package dp_pkg;
    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_EQ  = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        RES_ALU  = 2'd0,
        RES_MEM  = 2'd1,
        RES_RET  = 2'd2,
        RES_ALT  = 2'd3
    } res_sel_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_a_idx,
    input  logic [AW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_a_val,
    output logic [XLEN-1:0] rd_b_val,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_val
);
    logic [XLEN-1:0] row_q [NREG];
    logic [XLEN-1:0] row_d [NREG];

    always_comb begin
        row_d = row_q;
        if (wr_en) begin
            row_d[wr_idx] = wr_val;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[g] <= '0;
            end else begin
                row_q[g] <= row_d[g];
            end
        end
    end

    // reads see the value held before this cycle's write
    assign rd_a_val = row_q[rd_a_idx];
    assign rd_b_val = row_q[rd_b_idx];
endmodule

// File: rtl/dp_immext.sv
module dp_immext #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] raw,
    input  logic             signed_mode,
    output logic [XLEN-1:0]  ext
);
    localparam int PAD = XLEN - IMM_W;

    always_comb begin
        if (signed_mode) begin
            ext = {{PAD{raw[IMM_W-1]}}, raw};
        end else begin
            ext = {{PAD{1'b0}}, raw};
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res,
    output logic            same
);
    always_comb begin
        same = (opa == opb);
        unique case (op)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_EQ:  res = {{(XLEN-1){1'b0}}, same};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dp_core.sv
module dp_core
    import dp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int IMM_W = 16,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    src_a_addr,
    input  logic [AW-1:0]    src_b_addr,
    input  logic [AW-1:0]    dst_addr,
    input  logic [IMM_W-1:0] imm_field,
    input  logic             imm_signed,
    input  logic             use_imm,
    input  logic [2:0]       alu_op,
    input  logic [1:0]       res_sel,
    input  logic             rf_we,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic [XLEN-1:0]  ret_addr,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             cmp_eq
);
    typedef struct packed {
        logic [XLEN-1:0] opa;   // first source holder
        logic [XLEN-1:0] opb;   // second source holder
        logic [XLEN-1:0] res;   // ALU result / address holder
        logic [XLEN-1:0] sto;   // store data holder
        logic [XLEN-1:0] ret;   // value to retire
    } stage_t;

    stage_t st_d, st_q;

    logic [XLEN-1:0] rf_a_val, rf_b_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_same;

    dp_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a_addr),
        .rd_b_idx (src_b_addr),
        .rd_a_val (rf_a_val),
        .rd_b_val (rf_b_val),
        .wr_en    (rf_we),
        .wr_idx   (dst_addr),
        .wr_val   (st_q.ret)
    );

    dp_immext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
        .raw         (imm_field),
        .signed_mode (imm_signed),
        .ext         (imm_ext)
    );

    assign alu_b = use_imm ? imm_ext : st_q.opb;

    dp_alu #(.XLEN(XLEN)) u_alu (
        .op   (alu_op_e'(alu_op)),
        .opa  (st_q.opa),
        .opb  (alu_b),
        .res  (alu_res),
        .same (alu_same)
    );

    always_comb begin
        st_d     = st_q;
        st_d.opa = rf_a_val;
        st_d.opb = rf_b_val;
        st_d.res = alu_res;
        st_d.sto = st_q.opb;
        unique case (res_sel_e'(res_sel))
            RES_MEM: st_d.ret = mem_rdata;
            RES_RET: st_d.ret = ret_addr;
            default: st_d.ret = st_q.res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.res;
    assign mem_wdata = st_q.sto;
    assign cmp_eq    = alu_same;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      alu_op,
    input logic            use_imm,
    input logic [1:0]      res_sel,
    input logic [XLEN-1:0] mem_rdata,
    input logic [XLEN-1:0] ret_addr,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            cmp_eq,
    input logic [XLEN-1:0] opa_q,
    input logic [XLEN-1:0] opb_q,
    input logic [XLEN-1:0] ret_q,
    input logic [XLEN-1:0] imm_ext
);
    AST_ADD_TWO_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd0 && !use_imm) |=> (mem_addr == $past(opa_q) + $past(opb_q))); // R2
    AST_ADD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 3'd0 && use_imm) |=> (mem_addr == $past(opa_q) + $past(imm_ext))); // R3
    AST_STORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_wdata == $past(opb_q))); // R7
    AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_eq && !use_imm) |-> (opa_q == opb_q)); // R6
    AST_RET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == 2'd1) |=> (ret_q == $past(mem_rdata))); // R8
    AST_RET_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == 2'd2) |=> (ret_q == $past(ret_addr))); // R8
    AST_RET_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel == 2'd0) |=> (ret_q == $past(mem_addr))); // R8
endmodule

bind dp_core dp_core_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_op    (alu_op),
    .use_imm   (use_imm),
    .res_sel   (res_sel),
    .mem_rdata (mem_rdata),
    .ret_addr  (ret_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cmp_eq    (cmp_eq),
    .opa_q     (st_q.opa),
    .opb_q     (st_q.opb),
    .ret_q     (st_q.ret),
    .imm_ext   (imm_ext)
);

// File: tb/sim_dp_core.sv
module sim_dp_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_a_addr = '0, src_b_addr = '0, dst_addr = '0;
    logic [15:0] imm_field = '0;
    logic        imm_signed = 1'b0, use_imm = 1'b0, rf_we = 1'b0;
    logic [2:0]  alu_op = '0;
    logic [1:0]  res_sel = '0;
    logic [31:0] mem_rdata = '0, ret_addr = '0;
    logic [31:0] mem_addr, mem_wdata;
    logic        cmp_eq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_core u0 (
        .clk(clk), .rst_n(rst_n),
        .src_a_addr(src_a_addr), .src_b_addr(src_b_addr), .dst_addr(dst_addr),
        .imm_field(imm_field), .imm_signed(imm_signed), .use_imm(use_imm),
        .alu_op(alu_op), .res_sel(res_sel), .rf_we(rf_we),
        .mem_rdata(mem_rdata), .ret_addr(ret_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cmp_eq(cmp_eq)
    );

    typedef struct {
        int          due;
        int          sig;   // 0 mem_addr, 1 mem_wdata, 2 cmp_eq
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    logic [31:0] model [32];
    item_t       mit;
    logic [31:0] act;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each expected item in its due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            mit = sbq.pop_front();
            act = (mit.sig == 0) ? mem_addr : (mit.sig == 1) ? mem_wdata : {31'b0, cmp_eq};
            total++;
            if (mit.due != cyc || act !== mit.exp) begin
                bad++;
                $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h", mit.tag, mit.sig, cyc, act, mit.exp);
            end
        end
    end

    function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return {31'b0, a == b};
            default: return 32'h0;
        endcase
    endfunction

    task automatic push(input int due, input int sig, input logic [31:0] exp, input string tag);
        item_t it;
        it.due = due; it.sig = sig; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // drive one instruction across its steps and queue the expected results
    task automatic do_op(input logic [2:0] op, input int a, input int b, input int d,
                         input logic [15:0] imm, input logic sgn, input logic ui,
                         input logic [1:0] rsel, input logic we,
                         input logic [31:0] mrd, input logic [31:0] ret,
                         input logic rdw, input string tag);
        logic [31:0] av, bv, ix, ob, y, ry, old;
        int c0;
        av = model[a]; bv = model[b];
        ix = sgn ? {{16{imm[15]}}, imm} : {16'h0, imm};
        ob = ui ? ix : bv;
        y  = alu_ref(op, av, ob);
        ry = (rsel == 2'd1) ? mrd : (rsel == 2'd2) ? ret : y;
        old = model[d];
        c0 = cyc;
        src_a_addr = 5'(a); src_b_addr = 5'(b); dst_addr = 5'(d);
        imm_field = imm; imm_signed = sgn; use_imm = ui; alu_op = op;
        res_sel = rsel; mem_rdata = mrd; ret_addr = ret; rf_we = 1'b0;
        push(c0 + 1, 2, {31'b0, av == ob}, "R6");
        push(c0 + 2, 0, y, tag);
        push(c0 + 2, 1, bv, "R7");
        tick(); tick(); tick();
        rf_we = we;
        if (rdw) begin
            src_a_addr = 5'(d); alu_op = 3'd0; use_imm = 1'b1; imm_field = '0;
            push(c0 + 5, 0, old, "R11");
        end
        tick();
        rf_we = 1'b0;
        if (we) model[d] = ry;
        if (rdw) tick();
    endtask

    task automatic rd(input int r, input string tag);
        do_op(3'd0, r, 0, 0, 16'h0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push(cyc + 1, 0, 32'h0, "R1");
        push(cyc + 1, 1, 32'h0, "R1");
        tick();
        rd(0, "R1"); rd(5, "R1"); rd(31, "R1");
        // immediate into r1, memory into r2, return address into r3
        do_op(3'd0, 0, 0, 1, 16'h1234, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, 1'b0, "R3");
        rd(1, "R9");
        do_op(3'd0, 1, 1, 2, 16'h0, 1'b0, 1'b0, 2'd1, 1'b1, 32'hDEADBEEF, 32'h0, 1'b0, "R2");
        rd(2, "R8");
        do_op(3'd0, 0, 0, 3, 16'h0, 1'b0, 1'b0, 2'd2, 1'b1, 32'h0, 32'h00000400, 1'b0, "R2");
        rd(3, "R8");
        do_op(3'd0, 1, 0, 7, 16'h0004, 1'b0, 1'b1, 2'd3, 1'b1, 32'h0, 32'h0, 1'b0, "R3");
        rd(7, "R8");
        // immediate extension
        do_op(3'd0, 1, 0, 4, 16'h8001, 1'b1, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, 1'b0, "R4");
        do_op(3'd0, 1, 0, 5, 16'h8001, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, 1'b0, "R4");
        rd(4, "R4"); rd(5, "R4");
        // ALU functions
        do_op(3'd0, 2, 3, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R2");
        do_op(3'd1, 2, 1, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd1, 1, 2, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd2, 2, 4, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd3, 2, 3, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd4, 1, 1, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd4, 1, 2, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd4, 1, 0, 6, 16'h1234, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd5, 2, 3, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        do_op(3'd7, 2, 3, 6, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 1'b0, "R5");
        // write disabled leaves r1 unchanged
        do_op(3'd0, 0, 0, 1, 16'h0, 1'b0, 1'b0, 2'd1, 1'b0, 32'hFFFF0000, 32'h0, 1'b0, "R9");
        rd(1, "R9");
        // register 0 holds a written value
        do_op(3'd0, 0, 0, 0, 16'h0055, 1'b0, 1'b1, 2'd0, 1'b1, 32'h0, 32'h0, 1'b0, "R10");
        rd(0, "R10");
        // read during write sees the old contents
        do_op(3'd0, 0, 0, 1, 16'h0, 1'b0, 1'b0, 2'd2, 1'b1, 32'h0, 32'hCAFEF00D, 1'b1, "R11");
        rd(1, "R11");
        repeat (4) tick();
        if (sbq.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 pending=%0d expected=0", sbq.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog cyc=%0d expected=finish", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule